// File: doc/BRIEF.md
# Reloadable Periodic Tick Timer

A down-counting timer that produces a regular tick for an operating system or scheduler. The current value is `CNT_W` bits wide, 24 by default. It reloads itself automatically from a reload register. On each wrap it sets a sticky wrap flag and, when ticks are enabled, sends a one-cycle interrupt request to the interrupt controller that sits outside this block.

The counter steps once per count enable. The count enable comes either from every core clock cycle or from an internal prescaler that gives one enable every 8 core cycles. The prescaler makes no derived clock. One configure command sets up the timer in a single step:

- it checks the requested reload value against the counter width;
- it loads the reload register and clears the counter;
- it arms the interrupt, selects the full core clock and starts counting.

If the requested value is out of range, the command reports failure and changes nothing. Separate strobes write the control bits and the reload value, clear the current value, and read the control register. A control read clears the wrap flag.

Top module: `periodic_tick_timer`

## Requirements
- R1: A configure request whose value exceeds 2^CNT_W-1 (0xFFFFFF by default) sets `cfg_fail_o` to 1 on the next cycle and leaves every other register unchanged. A request in range, including exactly 0xFFFFFF, sets `cfg_fail_o` to 0.
- R2: A configure request that is in range does all of the following on the next cycle: it sets the reload value to the request, clears the counter and the wrap flag, and sets run, interrupt enable and full-clock source to 1.
- R3: On each count enable the counter behaves by its current value:
  - above 1, it decrements;
  - at 0, it loads the reload value and sets no flag;
  - at 1, it loads the reload value and this is a wrap.
  With reload N, wraps are therefore N count enables apart.
- R4: `tick_irq_o` is a one-cycle pulse. It appears the cycle after a wrap only if interrupt enable was 1; with interrupt enable 0, wraps raise no pulse.
- R5: With `src_full_o`=1 there is a count enable every core clock. With `src_full_o`=0 there is one count enable every 8 core clocks (reload 5 gives 40-cycle ticks).
- R6: A wrap sets `wrap_flag_o`, and it stays set until a `ctrl_rd_i` strobe clears it. If a wrap and a read fall in the same cycle, the flag stays set.
- R7: A `cur_we_i` strobe clears the counter and the wrap flag on the next cycle.
- R8: With a reload value of 0, the counter stays idle at 0 and no tick pulses occur.
- R9: After reset, all of the following are 0: counter, reload, wrap flag, run, interrupt enable, source select, `cfg_fail_o` and `tick_irq_o`.
- R10: A `ctrl_we_i` strobe loads run, interrupt enable and source select. While run is 0 the counter holds its value.
- R11: A `reload_we_i` strobe changes the reload value without changing the counter; the new value is used from the next reload on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_valid_i | input | 1 | Configure command strobe |
| cfg_reload_i | input | REQ_W | Requested reload value for configure |
| cfg_fail_o | output | 1 | Result of last configure: 1 = rejected |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_run_i | input | 1 | Run bit for control write |
| ctrl_irq_en_i | input | 1 | Interrupt enable bit for control write |
| ctrl_src_full_i | input | 1 | Source bit for control write: 1 full clock, 0 divide by 8 |
| ctrl_rd_i | input | 1 | Control read strobe, clears wrap flag |
| reload_we_i | input | 1 | Reload register write strobe |
| reload_data_i | input | CNT_W | Reload write data |
| cur_we_i | input | 1 | Current value write strobe, clears counter |
| run_o | output | 1 | Run bit |
| irq_en_o | output | 1 | Interrupt enable bit |
| src_full_o | output | 1 | Source select bit |
| wrap_flag_o | output | 1 | Sticky wrap flag |
| reload_o | output | CNT_W | Reload register |
| cur_o | output | CNT_W | Current counter value |
| tick_irq_o | output | 1 | One-cycle tick interrupt request |

## Verification
The properties assume that each strobe is a single-cycle pulse sampled at the rising edge, and that a configure command has priority over any write strobe in the same cycle. The down-step and hold properties exclude cycles carrying a configure or current-value write. The stimulus drives each strobe for exactly one cycle from the falling edge.

Most sequences keep strobes apart. The bench deliberately overlaps a control read with a wrap, using reload 1, to exercise the set-wins rule. A behavioural model that tracks the prescaler phase follows the clock-source switch. That switch is made while the timer is running.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned CNT_W_DEF = 24;
  localparam int unsigned REQ_W_DEF = 32;
  localparam int unsigned DIV_W_DEF = 3;

  typedef struct packed {
    logic run;
    logic irq_en;
    logic src_full;
  } tick_ctrl_t;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned DIV_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic clr_i,
  output logic pulse_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || !active_i) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // enable on last phase of each 2^DIV_W window
  assign pulse_o = active_i && (&cnt_q);
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned REQ_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_valid_i,
  input  logic [REQ_W-1:0] cfg_reload_i,
  input  logic             ctrl_we_i,
  input  tick_ctrl_t       ctrl_wdata_i,
  input  logic             reload_we_i,
  input  logic [CNT_W-1:0] reload_data_i,
  output tick_ctrl_t       ctrl_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             cfg_fail_o,
  output logic             cfg_apply_o
);
  logic over_range;

  generate
    if (REQ_W > CNT_W) begin : g_range
      assign over_range = |cfg_reload_i[REQ_W-1:CNT_W];
    end else begin : g_norange
      assign over_range = 1'b0;
    end
  endgenerate

  assign cfg_apply_o = cfg_valid_i && !over_range;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o     <= '0;
      reload_o   <= '0;
      cfg_fail_o <= 1'b0;
    end else if (cfg_valid_i) begin
      cfg_fail_o <= over_range;
      if (!over_range) begin
        reload_o <= cfg_reload_i[CNT_W-1:0];
        ctrl_o   <= '{run: 1'b1, irq_en: 1'b1, src_full: 1'b1};
      end
    end else begin
      if (ctrl_we_i)   ctrl_o   <= ctrl_wdata_i;
      if (reload_we_i) reload_o <= reload_data_i;
    end
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             irq_en_i,
  input  logic             rd_clr_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic wrap;
  assign wrap = cnt_en_i && (cur_o == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o  <= '0;
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else if (clr_i) begin
      cur_o  <= '0;
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (cnt_en_i) begin
        if (cur_o == '0 || cur_o == ONE) cur_o <= reload_i;
        else                             cur_o <= cur_o - ONE;
      end
      // set beats read-clear
      if (wrap)          flag_o <= 1'b1;
      else if (rd_clr_i) flag_o <= 1'b0;
      irq_o <= wrap && irq_en_i;
    end
  end
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned REQ_W = REQ_W_DEF,
  parameter int unsigned DIV_W = DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_valid_i,
  input  logic [REQ_W-1:0] cfg_reload_i,
  output logic             cfg_fail_o,
  input  logic             ctrl_we_i,
  input  logic             ctrl_run_i,
  input  logic             ctrl_irq_en_i,
  input  logic             ctrl_src_full_i,
  input  logic             ctrl_rd_i,
  input  logic             reload_we_i,
  input  logic [CNT_W-1:0] reload_data_i,
  input  logic             cur_we_i,
  output logic             run_o,
  output logic             irq_en_o,
  output logic             src_full_o,
  output logic             wrap_flag_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] cur_o,
  output logic             tick_irq_o
);
  tick_ctrl_t ctrl_q, ctrl_wdata;
  logic       cfg_apply, div_pulse, cnt_en, div_active;

  assign ctrl_wdata = '{run: ctrl_run_i, irq_en: ctrl_irq_en_i, src_full: ctrl_src_full_i};

  tick_regs #(.CNT_W(CNT_W), .REQ_W(REQ_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_valid_i   (cfg_valid_i),
    .cfg_reload_i  (cfg_reload_i),
    .ctrl_we_i     (ctrl_we_i),
    .ctrl_wdata_i  (ctrl_wdata),
    .reload_we_i   (reload_we_i),
    .reload_data_i (reload_data_i),
    .ctrl_o        (ctrl_q),
    .reload_o      (reload_o),
    .cfg_fail_o    (cfg_fail_o),
    .cfg_apply_o   (cfg_apply)
  );

  assign div_active = ctrl_q.run && !ctrl_q.src_full;

  tick_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (div_active),
    .clr_i    (cfg_apply || cur_we_i),
    .pulse_o  (div_pulse)
  );

  assign cnt_en = ctrl_q.run && (ctrl_q.src_full || div_pulse);

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cfg_apply || cur_we_i),
    .cnt_en_i (cnt_en),
    .reload_i (reload_o),
    .irq_en_i (ctrl_q.irq_en),
    .rd_clr_i (ctrl_rd_i),
    .cur_o    (cur_o),
    .flag_o   (wrap_flag_o),
    .irq_o    (tick_irq_o)
  );

  assign run_o      = ctrl_q.run;
  assign irq_en_o   = ctrl_q.irq_en;
  assign src_full_o = ctrl_q.src_full;
endmodule

// File: rtl/periodic_tick_timer_checker.sv
module periodic_tick_timer_checker #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned REQ_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_valid_i,
  input logic [REQ_W-1:0] cfg_reload_i,
  input logic             cfg_fail_o,
  input logic             reload_we_i,
  input logic             cur_we_i,
  input logic             run_o,
  input logic             irq_en_o,
  input logic             src_full_o,
  input logic             wrap_flag_o,
  input logic [CNT_W-1:0] reload_o,
  input logic [CNT_W-1:0] cur_o,
  input logic             tick_irq_o
);
  localparam logic [REQ_W-1:0] MAX_REQ = REQ_W'((64'd1 << CNT_W) - 64'd1);

  AST_CFG_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_valid_i && cfg_reload_i > MAX_REQ) |=> (cfg_fail_o && $stable(reload_o) && $stable(run_o))); // R1

  AST_CFG_APPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_valid_i && cfg_reload_i <= MAX_REQ) |=>
      (!cfg_fail_o && cur_o == '0 && !wrap_flag_o && run_o && irq_en_o && src_full_o
       && reload_o == $past(cfg_reload_i[CNT_W-1:0]))); // R2

  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && cur_o > CNT_W'(1) && !cfg_valid_i && !cur_we_i) |=>
      (cur_o == $past(cur_o) || cur_o == $past(cur_o) - CNT_W'(1))); // R3

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_irq_o |-> ($past(irq_en_o) && wrap_flag_o)); // R4

  AST_CUR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_we_i |=> (cur_o == '0 && !wrap_flag_o && !tick_irq_o)); // R7

  AST_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_o == '0 && cur_o == '0 && !cfg_valid_i && !reload_we_i) |=>
      (cur_o == '0 && !tick_irq_o)); // R8

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !cfg_valid_i && !cur_we_i) |=> $stable(cur_o)); // R10
endmodule

bind periodic_tick_timer periodic_tick_timer_checker #(.CNT_W(CNT_W), .REQ_W(REQ_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_valid_i  (cfg_valid_i),
  .cfg_reload_i (cfg_reload_i),
  .cfg_fail_o   (cfg_fail_o),
  .reload_we_i  (reload_we_i),
  .cur_we_i     (cur_we_i),
  .run_o        (run_o),
  .irq_en_o     (irq_en_o),
  .src_full_o   (src_full_o),
  .wrap_flag_o  (wrap_flag_o),
  .reload_o     (reload_o),
  .cur_o        (cur_o),
  .tick_irq_o   (tick_irq_o)
);

// File: tb/periodic_tick_timer_bench.sv
module periodic_tick_timer_bench;
  localparam int CLK_P = 10;
  localparam int CNT_W = 24;
  localparam int REQ_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 0, ctrl_we = 0, ctrl_run = 0, ctrl_ie = 0, ctrl_full = 0;
  logic ctrl_rd = 0, reload_we = 0, cur_we = 0;
  logic [REQ_W-1:0] cfg_req = '0;
  logic [CNT_W-1:0] reload_d = '0;
  logic cfg_fail, run, ie, full, flag, irq;
  logic [CNT_W-1:0] reload, cur;

  int checks = 0, failures = 0;
  bit done = 0;
  bit cmp_en = 0;

  always #(CLK_P/2) clk = ~clk;

  periodic_tick_timer u_periodic_tick_timer (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_valid_i(cfg_valid), .cfg_reload_i(cfg_req), .cfg_fail_o(cfg_fail),
    .ctrl_we_i(ctrl_we), .ctrl_run_i(ctrl_run), .ctrl_irq_en_i(ctrl_ie),
    .ctrl_src_full_i(ctrl_full), .ctrl_rd_i(ctrl_rd),
    .reload_we_i(reload_we), .reload_data_i(reload_d), .cur_we_i(cur_we),
    .run_o(run), .irq_en_o(ie), .src_full_o(full), .wrap_flag_o(flag),
    .reload_o(reload), .cur_o(cur), .tick_irq_o(irq)
  );

  // behavioural reference
  longint m_cur, m_rel;
  bit m_flag, m_irq, m_run, m_ie, m_full, m_fail;
  int m_ph;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 0; m_rel = 0; m_flag = 0; m_irq = 0;
      m_run = 0; m_ie = 0; m_full = 0; m_fail = 0; m_ph = 0;
    end else begin
      bit act, en, ok, wrap;
      act = m_run && !m_full;
      en  = m_run && (m_full || (act && m_ph == 7));
      ok  = cfg_valid && (cfg_req <= 32'h00FF_FFFF);
      wrap = 0;
      if (ok || cur_we) begin
        m_cur = 0; m_flag = 0; m_irq = 0;
      end else begin
        if (en) begin
          if (m_cur == 1) wrap = 1;
          if (m_cur <= 1) m_cur = m_rel; else m_cur = m_cur - 1;
        end
        if (wrap) m_flag = 1; else if (ctrl_rd) m_flag = 0;
        m_irq = wrap && m_ie;
      end
      if (ok || cur_we || !act) m_ph = 0; else m_ph = (m_ph + 1) % 8;
      if (cfg_valid) begin
        m_fail = !ok;
        if (ok) begin m_rel = cfg_req; m_run = 1; m_ie = 1; m_full = 1; end
      end else begin
        if (ctrl_we) begin m_run = ctrl_run; m_ie = ctrl_ie; m_full = ctrl_full; end
        if (reload_we) m_rel = reload_d;
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && cmp_en && !done) begin
    chk("R3 model cur", cur, m_cur);
    chk("R2 model reload", reload, m_rel);
    chk("R6 model flag", flag, m_flag);
    chk("R4 model irq", irq, m_irq);
    chk("R1 model fail", cfg_fail, m_fail);
    chk("R10 model ctrl", {run, ie, full}, {m_run, m_ie, m_full});
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_cfg(logic [31:0] v);
    cfg_valid = 1; cfg_req = v; @(negedge clk); cfg_valid = 0;
  endtask

  task automatic do_ctrl(bit r, bit e, bit f);
    ctrl_we = 1; ctrl_run = r; ctrl_ie = e; ctrl_full = f; @(negedge clk); ctrl_we = 0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq && n < 2000);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int n, cnt;
    logic [CNT_W-1:0] held;
    cyc(3);
    rst_n = 1;
    cmp_en = 1;
    cyc(1);
    // R9 reset state
    chk("R9 cur", cur, 0);
    chk("R9 reload", reload, 0);
    chk("R9 ctrl", {run, ie, full, flag, cfg_fail, irq}, 0);

    // R1 reject
    do_cfg(32'h0100_0000);
    chk("R1 fail set", cfg_fail, 1);
    chk("R1 reload kept", reload, 0);
    chk("R1 run kept", run, 0);

    // R2 apply
    do_cfg(32'd5);
    chk("R2 fail clr", cfg_fail, 0);
    chk("R2 reload", reload, 5);
    chk("R2 cur", cur, 0);
    chk("R2 ctrl", {run, ie, full}, 3'b111);

    // R3 / R4 period
    wait_irq(n);
    wait_irq(n);
    chk("R3 period 5", n, 5);
    chk("R6 flag set", flag, 1);
    ctrl_rd = 1; @(negedge clk); ctrl_rd = 0;
    chk("R4 pulse width", irq, 0);
    chk("R6 read clears", flag, 0);

    // R5 divide by 8
    do_ctrl(1, 1, 0);
    wait_irq(n);
    wait_irq(n);
    chk("R5 period 40", n, 40);

    // R4 irq disabled
    do_ctrl(1, 0, 1);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (irq) cnt++; end
    chk("R4 no pulse when disabled", cnt, 0);
    chk("R4 flag still sets", flag, 1);

    // R7 current write
    cur_we = 1; @(negedge clk); cur_we = 0;
    chk("R7 cur cleared", cur, 0);
    chk("R7 flag cleared", flag, 0);

    // R11 reload write
    do_ctrl(1, 1, 1);
    cyc(3);
    held = cur;
    reload_we = 1; reload_d = 24'd3; @(negedge clk); reload_we = 0;
    chk("R11 reload", reload, 3);
    chk("R11 cur untouched", cur, (held <= 1) ? 5 : held - 1);
    wait_irq(n);
    wait_irq(n);
    chk("R11 new period", n, 3);

    // R10 stop holds
    do_ctrl(0, 1, 1);
    held = cur;
    cyc(10);
    chk("R10 stopped hold", cur, held);

    // R6 set wins over read
    do_cfg(32'd1);
    cyc(3);
    ctrl_rd = 1; @(negedge clk); ctrl_rd = 0;
    chk("R6 set beats read", flag, 1);

    // R1 boundary
    do_cfg(32'h00FF_FFFF);
    chk("R1 max accepted", cfg_fail, 0);
    chk("R1 max reload", reload, 24'hFF_FFFF);
    do_cfg(32'hFFFF_FFFF);
    chk("R1 reject keeps reload", reload, 24'hFF_FFFF);
    chk("R1 reject flag", cfg_fail, 1);

    // R8 zero reload
    do_cfg(32'd0);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (irq || cur != 0) cnt++; end
    chk("R8 idle at zero", cnt, 0);

    cyc(2);
    finish_run();
  end
endmodule